// File: doc/BRIEF.md
# Status-Change Interrupt Control Unit

This block drives interrupts for a card socket from card-side event lines. It holds an 8-bit socket control register and a bank of sticky status-change flags, both reached over a simple byte-wide register bus with address, write strobe, read strobe and data. Each event line sets its own flag. A flag stays set until software clears it, in whichever of two ways the control register selects.

There are two host interrupt outputs. One comes from the status-change flags. The other follows a functional interrupt request from the card. Each can signal as a one-clock pulse or as a steady level, chosen independently in the control register. A power-down bit gates the enable for the card-side output drivers. When the bit is set, the drivers are enabled only while an active card cycle is running. The flags and the functional interrupt path keep working in power-down.

Register map: address 0 is the control register. Address 1 is the flag register, with flag i at bit i and the bits above the flags reading zero. Any other address reads zero, and writes to it are ignored.

Top module: `stchg_irq_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the control register and the flags go to zero and csc_irq and func_irq go low. card_oe is then 1.
- R2: A write to address 0 stores data bits 4:0. Bits 7:5 always read as zero, and writing them has no effect. Bit 4 reads back what was written and drives nothing.
- R3: An event line that is high at a clock edge sets flag i (bit i at address 1). The flag then stays set until it is cleared as in R4 or R5.
- R4: With control bit 2 = 0, a read of address 1 returns the current flags and clears all of them at that edge. An event high in the same cycle leaves its flag set. Writes to address 1 do nothing in this mode.
- R5: With control bit 2 = 1, a write to address 1 clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged. An event in the same cycle wins over the clear. Reads of address 1 clear nothing.
- R6: With control bit 1 = 0, csc_irq is high for exactly the one cycle after each edge at which at least one flag goes from clear to set.
- R7: With control bit 1 = 1, csc_irq is high whenever any flag is set.
- R8: With control bit 3 = 0, func_irq pulses for one cycle after the edge at which func_req is first sampled high. With bit 3 = 1, func_irq equals func_req as sampled at the last edge.
- R9: With control bit 0 = 1, card_oe equals card_cycle. With bit 0 = 0, card_oe is 1.
- R10: While control bit 0 = 1, events still set flags and still raise csc_irq, and func_req still drives func_irq.
- R11: bus_rdata is zero when bus_rd is low, and when the read address is neither 0 nor 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears flags in clear-on-read mode) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| evt_csc | input | 4 | Status-change event lines, one per flag |
| func_req | input | 1 | Functional interrupt request from the card |
| card_cycle | input | 1 | High while an active card access cycle runs |
| card_oe | output | 1 | Output enable for the card-side drivers |
| csc_irq | output | 1 | Status-change host interrupt |
| func_irq | output | 1 | Functional host interrupt |

## Verification
The bench targets a read of the flags that coincides with a new event. A design that let the clear win would lose that event for good, and csc_irq would stay silent. It writes 0 and 1 patterns in write-one-to-clear mode and reads in that mode, to catch a design that clears unwritten flags or treats reads as clears. It also sets an already-set flag, which must give no second pulse, and holds func_req high across several cycles, which must give one pulse. A design that detected levels instead of edges would pulse repeatedly. Finally it sends events while in power-down and toggles card_cycle. A design that gated the flags with power-down, or latched the enable, would differ from the model on the first such cycle.

// File: rtl/stchg_pkg.sv
// Shared constants for the status-change interrupt unit: the register map and
// the positions of the mode bits inside the control register.
package stchg_pkg;
    localparam int CTL_ADDR    = 0;
    localparam int FLG_ADDR    = 1;
    localparam int BIT_PWRDN   = 0;
    localparam int BIT_CSC_LVL = 1;
    localparam int BIT_W1C     = 2;
    localparam int BIT_FUNC_LVL= 3;
    localparam int RSVD_LSB    = 5;  // bits at and above this read zero

    typedef struct packed {
        logic func_lvl;
        logic w1c;
        logic csc_lvl;
        logic pwrdn;
    } mode_t;
endpackage

// File: rtl/stchg_ctl_reg.sv
// Control register. It stores the writable low bits on a write hit; the bits
// at and above RSVD_LSB are held at zero. Assumes DW > RSVD_LSB.
module stchg_ctl_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctl_q
);
    import stchg_pkg::*;
    localparam logic [DW-1:0] WMASK = DW'((1 << RSVD_LSB) - 1);

    // Register update: reset to zero, masked store on a write hit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_hit) ctl_q <= wdata & WMASK;
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[DW-1:RSVD_LSB] == '0);
    assert_ctl_reset_R1: assert property (@(posedge clk) !rst_n |=> ctl_q == '0);
endmodule

// File: rtl/stchg_flag_bank.sv
// Sticky status-change flags. Each flag is set by its event line, and is cleared
// either by a read hit (clear-on-read) or by a 1 in the write data
// (write-one-to-clear). A set in the same cycle always wins over a clear.
module stchg_flag_bank #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] evt,
    input  logic          rd_hit,
    input  logic          wr_hit,
    input  logic [NF-1:0] wmask,
    input  logic          w1c,
    output logic [NF-1:0] flags_q,
    output logic          any_rise
);
    logic [NF-1:0] nxt;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic clr;
        // Per-flag clear decision for the selected clearing mode.
        always_comb clr = w1c ? (wr_hit & wmask[i]) : rd_hit;
        // Per-flag next value: keep unless cleared, set by event.
        always_comb nxt[i] = (flags_q[i] & ~clr) | evt[i];
        // Per-flag storage.
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[i] <= 1'b0;
            else        flags_q[i] <= nxt[i];
        end
    end

    // Detects any flag about to go from clear to set.
    always_comb any_rise = |(nxt & ~flags_q);

    assert_sticky_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));
    assert_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && rd_hit && !wr_hit) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/stchg_irq_gen.sv
// Interrupt signalling. It turns the flag state and the functional request into
// pulse-or-level host interrupts. Both outputs are registered-state driven.
module stchg_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic csc_lvl,
    input  logic func_lvl,
    input  logic flags_any,
    input  logic flag_rise,
    input  logic func_req,
    output logic csc_irq,
    output logic func_irq
);
    logic csc_pulse_q, func_q, func_pulse_q;

    // Pulse and sample registers for both interrupt sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csc_pulse_q  <= 1'b0;
            func_q       <= 1'b0;
            func_pulse_q <= 1'b0;
        end else begin
            csc_pulse_q  <= flag_rise;
            func_q       <= func_req;
            func_pulse_q <= func_req & ~func_q;
        end
    end

    // Output selection: level or pulse form for each source.
    always_comb begin
        csc_irq  = csc_lvl  ? flags_any : csc_pulse_q;
        func_irq = func_lvl ? func_q    : func_pulse_q;
    end

    assert_func_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!func_lvl && func_irq) |=> (func_lvl || !func_irq));
endmodule

// File: rtl/stchg_drv_gate.sv
// Card driver enable. In power-down the drivers are enabled only while an active
// card cycle is flagged; otherwise they are always enabled.
module stchg_drv_gate (
    input  logic pwrdn,
    input  logic card_cycle,
    output logic card_oe
);
    // Enable policy.
    always_comb card_oe = pwrdn ? card_cycle : 1'b1;
endmodule

// File: rtl/stchg_irq_unit.sv
// Top level: register decode and read mux, plus the four sub-blocks.
// Assumes NF <= DW and an address width able to hold both register addresses.
module stchg_irq_unit #(
    parameter int AW = 2,
    parameter int DW = 8,
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NF-1:0] evt_csc,
    input  logic          func_req,
    input  logic          card_cycle,
    output logic          card_oe,
    output logic          csc_irq,
    output logic          func_irq
);
    import stchg_pkg::*;

    logic          sel_ctl, sel_flg;
    logic [DW-1:0] ctl_q;
    logic [NF-1:0] flags_q;
    logic          any_rise;
    mode_t         mode;

    // Address decode.
    always_comb begin
        sel_ctl = (bus_addr == AW'(CTL_ADDR));
        sel_flg = (bus_addr == AW'(FLG_ADDR));
    end

    // Mode field extraction from the control register.
    always_comb begin
        mode.pwrdn    = ctl_q[BIT_PWRDN];
        mode.csc_lvl  = ctl_q[BIT_CSC_LVL];
        mode.w1c      = ctl_q[BIT_W1C];
        mode.func_lvl = ctl_q[BIT_FUNC_LVL];
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && sel_ctl)      bus_rdata = ctl_q;
        else if (bus_rd && sel_flg) bus_rdata = {{(DW-NF){1'b0}}, flags_q};
    end

    stchg_ctl_reg #(.DW(DW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_hit(bus_wr && sel_ctl),
        .wdata(bus_wdata), .ctl_q(ctl_q)
    );

    stchg_flag_bank #(.NF(NF)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt_csc),
        .rd_hit(bus_rd && sel_flg), .wr_hit(bus_wr && sel_flg),
        .wmask(bus_wdata[NF-1:0]), .w1c(mode.w1c),
        .flags_q(flags_q), .any_rise(any_rise)
    );

    stchg_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .csc_lvl(mode.csc_lvl), .func_lvl(mode.func_lvl),
        .flags_any(|flags_q), .flag_rise(any_rise), .func_req(func_req),
        .csc_irq(csc_irq), .func_irq(func_irq)
    );

    stchg_drv_gate u_drv (
        .pwrdn(mode.pwrdn), .card_cycle(card_cycle), .card_oe(card_oe)
    );

    assert_level_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.csc_lvl && (|flags_q)) |-> csc_irq);
    assert_pwrdn_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.pwrdn && !card_cycle) |-> !card_oe);
endmodule

// File: tb/stchg_irq_unit_tb.sv
module stchg_irq_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] evt_csc = '0;
    logic       func_req = 1'b0, card_cycle = 1'b0;
    logic       card_oe, csc_irq, func_irq;

    int total = 0, bad = 0;
    bit done = 0;
    string ph = "R1";

    // Behavioural reference state.
    logic [7:0] m_ctl = '0;
    logic [3:0] m_flg = '0;
    bit m_cp = 0, m_fq = 0, m_fp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stchg_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_csc(evt_csc), .func_req(func_req), .card_cycle(card_cycle),
        .card_oe(card_oe), .csc_irq(csc_irq), .func_irq(func_irq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (phase %s): actual=%h expected=%h at %0t", req, ph, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model for the inputs now applied.
    task automatic compare();
        logic [7:0] e_rd;
        e_rd = 8'h00;
        if (bus_rd && bus_addr == 2'd0) e_rd = m_ctl;
        else if (bus_rd && bus_addr == 2'd1) e_rd = {4'h0, m_flg};
        chk((bus_addr == 2'd1) ? (m_ctl[2] ? "R5 rdata" : "R4 rdata")
            : (bus_addr == 2'd0 ? "R2 rdata" : "R11 rdata"), bus_rdata, e_rd);
        chk("R9 card_oe", {7'h0, card_oe}, {7'h0, m_ctl[0] ? card_cycle : 1'b1});
        chk(m_ctl[1] ? "R7 csc_irq" : "R6 csc_irq", {7'h0, csc_irq},
            {7'h0, m_ctl[1] ? (m_flg != 0) : m_cp});
        chk("R8 func_irq", {7'h0, func_irq}, {7'h0, m_ctl[3] ? m_fq : m_fp});
    endtask

    // One clock: check, advance model at the edge, return at the negedge.
    task automatic step();
        logic [3:0] nf;
        #1 compare();
        @(posedge clk);
        nf = m_flg;
        if (bus_rd && bus_addr == 2'd1 && !m_ctl[2]) nf = 4'h0;
        if (bus_wr && bus_addr == 2'd1 && m_ctl[2])  nf = nf & ~bus_wdata[3:0];
        nf = nf | evt_csc;
        m_cp = ((nf & ~m_flg) != 0);
        m_fp = func_req && !m_fq;
        m_fq = func_req;
        if (bus_wr && bus_addr == 2'd0) m_ctl = bus_wdata & 8'h1F;
        m_flg = nf;
        @(negedge clk);
    endtask

    task automatic cyc(logic [1:0] a, bit w, bit r, logic [7:0] d,
                       logic [3:0] e, bit f, bit c);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        evt_csc = e; func_req = f; card_cycle = c;
        step();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(2'd0, 0, 0, 8'h00, 4'h0, func_req, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 card_oe", {7'h0, card_oe}, 8'h01);
        chk("R1 csc_irq", {7'h0, csc_irq}, 8'h00);
        chk("R1 func_irq", {7'h0, func_irq}, 8'h00);
        rst_n = 1'b1;
        ph = "R1"; cyc(2'd0, 0, 1, 0, 0, 0, 0); cyc(2'd1, 0, 1, 0, 0, 0, 0);

        ph = "R2";
        cyc(2'd0, 1, 0, 8'hFF, 0, 0, 0); cyc(2'd0, 0, 1, 0, 0, 0, 0);
        cyc(2'd0, 1, 0, 8'hF0, 0, 0, 0); cyc(2'd0, 0, 1, 0, 0, 0, 0);
        cyc(2'd0, 1, 0, 8'h00, 0, 0, 0);

        ph = "R3";  // event, sticky, second event on a set flag: no second pulse
        cyc(2'd0, 0, 0, 0, 4'h4, 0, 0); idle(3);
        cyc(2'd0, 0, 0, 0, 4'h4, 0, 0); idle(2);
        cyc(2'd2, 1, 1, 8'hFF, 0, 0, 0);  // R11 unmapped address
        ph = "R4";
        cyc(2'd1, 1, 0, 8'hFF, 0, 0, 0);  // write ignored in clear-on-read
        cyc(2'd1, 0, 1, 0, 0, 0, 0); cyc(2'd1, 0, 1, 0, 0, 0, 0);
        cyc(2'd0, 0, 0, 0, 4'h3, 0, 0);
        cyc(2'd1, 0, 1, 0, 4'h8, 0, 0);   // read + new event: event survives
        cyc(2'd1, 0, 1, 0, 0, 0, 0); idle(1);

        ph = "R5";
        cyc(2'd0, 1, 0, 8'h06, 0, 0, 0);
        cyc(2'd0, 0, 0, 0, 4'hF, 0, 0);
        cyc(2'd1, 0, 1, 0, 0, 0, 0); cyc(2'd1, 0, 1, 0, 0, 0, 0);
        cyc(2'd1, 1, 0, 8'h00, 0, 0, 0); cyc(2'd1, 0, 1, 0, 0, 0, 0);
        cyc(2'd1, 1, 0, 8'h05, 0, 0, 0); cyc(2'd1, 0, 1, 0, 0, 0, 0);
        cyc(2'd1, 1, 0, 8'h0A, 4'h2, 0, 0); cyc(2'd1, 0, 1, 0, 0, 0, 0);
        ph = "R7";
        cyc(2'd1, 1, 0, 8'h02, 0, 0, 0); idle(2);

        ph = "R8";
        cyc(2'd0, 1, 0, 8'h00, 0, 0, 0);
        cyc(2'd0, 0, 0, 0, 0, 1, 0); idle(4);
        cyc(2'd0, 0, 0, 0, 0, 0, 0); cyc(2'd0, 0, 0, 0, 0, 1, 0);
        cyc(2'd0, 1, 0, 8'h08, 0, 1, 0); idle(2);
        cyc(2'd0, 0, 0, 0, 0, 0, 0); idle(2);

        ph = "R9";
        cyc(2'd0, 1, 0, 8'h01, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(2'd0, 0, 0, 0, 0, 0, i[0]);
        ph = "R10";
        cyc(2'd0, 0, 0, 0, 4'h1, 1, 1); idle(2);
        cyc(2'd1, 0, 1, 0, 0, 0, 0); idle(1);

        ph = "R3";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[1:0], r[2] & r[3], r[4], (r[5] ? r[15:8] & 8'h1F : r[15:8]),
                (r[16] ? r[20:17] : 4'h0), r[21], r[22]);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule